// File: doc/BRIEF.md
# Keyed Configuration Port with Banked Device Registers

This block is the configuration front end of a peripheral controller. It decodes two consecutive byte addresses on a simple I/O bus. These are an index/key port at `CFG_BASE` and a data port at `CFG_BASE+1`. The bus is byte-wide and carries a 16-bit address, a write strobe, a read strobe and write data. The read data is combinational while the read strobe is high.

Configuration access is normally locked. Writing the unlock key to the index port opens it, and writing the lock key closes it again. While the port is unlocked, a byte written to the index port selects a register, and the data port reads or writes that register.

A logical-device select register picks which bank of per-device base-address registers is visible. The runtime device's base address is always exported, together with a hit flag for its 256-byte I/O window. A fixed device ID and a revision byte can be read back.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfg_mode`=0), the index and device-select registers are 0x00, every bank's base address is 0x0000, and `rt_base` is 0x0000.
- R2: While locked, writing 0x55 to the index port unlocks it from the next cycle. While unlocked, writing 0xAA to the index port locks it from the next cycle, and the index is left unchanged.
- R3: While locked, every write to the index port other than 0x55 and every write to the data port is ignored. Reads at either port return 0xFF.
- R4: While unlocked, a write to the index port of any byte except 0xAA sets the index, including 0x55. A read of the index port returns the index, and the data port reads or writes the indexed register.
- R5: Index 0x07 is the 8-bit logical-device select register and can be both read and written.
- R6: Index 0x20 reads the device ID (default 0x7D) and index 0x21 reads the revision (default 0x01). Writes to either are discarded.
- R7: Indices 0x60 and 0x61 are the high and low bytes of the selected device's 16-bit base address. Each device number below `NUM_LDEV` (16) has its own storage. For a select value of `NUM_LDEV` or more, these indices read 0x00 and writes to them are discarded.
- R8: `rt_base` equals the stored base of device 0x0A in the cycle after a write to it, whatever the select is afterwards.
- R9: `rt_hit` is 1 exactly when `rt_base` is nonzero and `io_addr` lies in `rt_base` to `rt_base+255` (no wrap past 0xFFFF).
- R10: While unlocked, indices other than 0x07, 0x20, 0x21, 0x60 and 0x61 read 0x00, and writes to them are ignored.
- R11: The index and select registers keep their values across locking and unlocking.
- R12: A read in the same cycle as a write returns the value held before the write.
- R13: Bus cycles at addresses other than the two ports change nothing, and reads there return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Bus address |
| io_wr | input | 1 | Write strobe, sampled at the clock edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while `io_rd` is high |
| cfg_mode | output | 1 | 1 while configuration access is unlocked |
| rt_base | output | 16 | Base address of the runtime device |
| rt_hit | output | 1 | `io_addr` falls in the runtime window |

## Verification
A read and a write can fall in the same cycle. A data-port read together with a write to the same register must show the old contents. An index-port read together with a lock-key write must show the index, with the lock taking effect only afterwards. The bench forces both cases directly. Its random traffic also raises both strobes together often, and it compares every read against a model whose state advances only after the read has been judged.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_UNLOCK  = 8'h55;
  localparam logic [7:0] KEY_LOCK    = 8'hAA;
  localparam logic [7:0] IDX_LDSEL   = 8'h07;
  localparam logic [7:0] IDX_DEVID   = 8'h20;
  localparam logic [7:0] IDX_REV     = 8'h21;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam int         WIN_BYTES   = 256;

  // Non-wrapping window test; a zero base disables the window.
  function automatic logic in_window(input logic [15:0] a, input logic [15:0] base);
    logic [16:0] off;
    off = {1'b0, a} - {1'b0, base};
    return (base != 16'h0) && (a >= base) && (off < 17'(WIN_BYTES));
  endfunction
endpackage

// File: rtl/sio_cfg_lock.sv
module sio_cfg_lock
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       unlocked
);
  logic enter_evt, exit_evt;

  assign enter_evt = key_wr && !unlocked && (key_data == KEY_UNLOCK);
  assign exit_evt  = key_wr &&  unlocked && (key_data == KEY_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         unlocked <= 1'b0;
    else if (enter_evt) unlocked <= 1'b1;
    else if (exit_evt)  unlocked <= 1'b0;
  end

  AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> unlocked); // R2
  AST_LOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> !unlocked); // R2
  AST_NO_SPURIOUS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !(key_wr && key_data == KEY_UNLOCK)) |=> !unlocked); // R3
endmodule

// File: rtl/sio_base_bank.sv
module sio_base_bank #(
  parameter int NUM_LDEV = 16,
  parameter int RT_LDEV  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sel,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic [7:0]  wdata,
  output logic [15:0] sel_base,
  output logic [15:0] rt_base
);
  localparam int LDEV_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;

  logic              sel_ok;
  logic [LDEV_W-1:0] sel_idx;
  logic [15:0]       base_q [NUM_LDEV];

  assign sel_ok  = int'(sel) < NUM_LDEV;
  assign sel_idx = sel[LDEV_W-1:0];

  for (genvar g = 0; g < NUM_LDEV; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= 16'h0;
      end else if (sel_ok && sel_idx == LDEV_W'(g)) begin
        if (wr_hi) base_q[g][15:8] <= wdata;
        if (wr_lo) base_q[g][7:0]  <= wdata;
      end
    end
  end

  assign sel_base = sel_ok ? base_q[sel_idx] : 16'h0;
  assign rt_base  = base_q[RT_LDEV];

  AST_RT_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && int'(sel) == RT_LDEV) |=> rt_base[15:8] == $past(wdata)); // R8
  AST_RT_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && int'(sel) == RT_LDEV) |=> rt_base[7:0] == $past(wdata)); // R8
  AST_RT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) != RT_LDEV) |=> $stable(rt_base)); // R8
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CFG_BASE = 16'h002E,
  parameter logic [7:0]  DEV_ID   = 8'h7D,
  parameter logic [7:0]  REV_ID   = 8'h01,
  parameter int          NUM_LDEV = 16,
  parameter int          RT_LDEV  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        cfg_mode,
  output logic [15:0] rt_base,
  output logic        rt_hit
);
  localparam logic [15:0] DATA_PORT = CFG_BASE + 16'd1;

  logic        hit_idx, hit_dat;
  logic        key_wr, idx_wr, dat_wr;
  logic        sel_wr, hi_wr, lo_wr;
  logic [7:0]  idx_q, sel_q, reg_rd;
  logic [15:0] sel_base;

  assign hit_idx = (io_addr == CFG_BASE);
  assign hit_dat = (io_addr == DATA_PORT);
  assign key_wr  = io_wr && hit_idx;
  assign idx_wr  = key_wr && cfg_mode && (io_wdata != KEY_LOCK);
  assign dat_wr  = io_wr && hit_dat && cfg_mode;
  assign sel_wr  = dat_wr && (idx_q == IDX_LDSEL);
  assign hi_wr   = dat_wr && (idx_q == IDX_BASE_HI);
  assign lo_wr   = dat_wr && (idx_q == IDX_BASE_LO);

  sio_cfg_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (io_wdata),
    .unlocked (cfg_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h0;
      sel_q <= 8'h0;
    end else begin
      if (idx_wr) idx_q <= io_wdata;
      if (sel_wr) sel_q <= io_wdata;
    end
  end

  sio_base_bank #(.NUM_LDEV(NUM_LDEV), .RT_LDEV(RT_LDEV)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel_q),
    .wr_hi    (hi_wr),
    .wr_lo    (lo_wr),
    .wdata    (io_wdata),
    .sel_base (sel_base),
    .rt_base  (rt_base)
  );

  always_comb begin
    unique case (idx_q)
      IDX_LDSEL:   reg_rd = sel_q;
      IDX_DEVID:   reg_rd = DEV_ID;
      IDX_REV:     reg_rd = REV_ID;
      IDX_BASE_HI: reg_rd = sel_base[15:8];
      IDX_BASE_LO: reg_rd = sel_base[7:0];
      default:     reg_rd = 8'h00;
    endcase
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && cfg_mode) begin
      if (hit_idx)      io_rdata = idx_q;
      else if (hit_dat) io_rdata = reg_rd;
    end
  end

  assign rt_hit = in_window(io_addr, rt_base);

  AST_LOCKED_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(idx_q)); // R3
  AST_LOCKED_SELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(sel_q)); // R11
  AST_DEVID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit_dat && cfg_mode && idx_q == IDX_DEVID) |-> io_rdata == DEV_ID); // R6
  AST_FOREIGN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_idx && !hit_dat) |=> ($stable(idx_q) && $stable(sel_q) && $stable(cfg_mode))); // R13
endmodule

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] P0 = 16'h002E;
  localparam logic [15:0] P1 = 16'h002F;
  localparam logic [7:0]  ID = 8'h7D;
  localparam logic [7:0]  RV = 8'h01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        cfg_mode, rt_hit;
  logic [15:0] rt_base;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic        m_mode;
  logic [7:0]  m_idx, m_sel;
  logic [15:0] m_base [256];

  sio_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_mode(cfg_mode),
    .rt_base(rt_base), .rt_hit(rt_hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    logic [15:0] b;
    b = (m_sel < 8'd16) ? m_base[m_sel] : 16'h0;
    if (!m_mode || (a != P0 && a != P1)) return 8'hFF;
    if (a == P0) return m_idx;
    case (m_idx)
      8'h07:   return m_sel;
      8'h20:   return ID;
      8'h21:   return RV;
      8'h60:   return b[15:8];
      8'h61:   return b[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_hit(input logic [15:0] a);
    int base;
    base = int'(m_base[10]);
    return (base != 0) && (int'(a) >= base) && (int'(a) <= base + 255);
  endfunction

  task automatic model_step(input logic [15:0] a, input logic w, input logic [7:0] d);
    if (!w) return;
    if (a == P0) begin
      if (!m_mode) begin
        if (d == 8'h55) m_mode = 1'b1;
      end else if (d == 8'hAA) m_mode = 1'b0;
      else m_idx = d;
    end else if (a == P1 && m_mode) begin
      if (m_idx == 8'h07) m_sel = d;
      else if (m_idx == 8'h60 && m_sel < 8'd16) m_base[m_sel][15:8] = d;
      else if (m_idx == 8'h61 && m_sel < 8'd16) m_base[m_sel][7:0] = d;
    end
  endtask

  // One bus cycle: check registered state, drive, check combinational outputs, advance model.
  task automatic op(input string req, input logic [15:0] a, input logic w, input logic r,
                    input logic [7:0] d);
    @(negedge clk);
    check("R2 cfg_mode", {15'h0, cfg_mode}, {15'h0, m_mode});
    check("R8 rt_base", rt_base, m_base[10]);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
    #1;
    if (r) check(req, {8'h0, io_rdata}, {8'h0, exp_read(a)});
    check("R9 rt_hit", {15'h0, rt_hit}, {15'h0, exp_hit(a)});
    model_step(a, w, d);
  endtask

  task automatic wr(input string req, input logic [15:0] a, input logic [7:0] d);
    op(req, a, 1'b1, 1'b0, d);
  endtask
  task automatic rd(input string req, input logic [15:0] a);
    op(req, a, 1'b0, 1'b1, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_mode = 1'b0; m_idx = 8'h0; m_sel = 8'h0;
    for (int i = 0; i < 256; i++) m_base[i] = 16'h0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 mode", {15'h0, cfg_mode}, 16'h0);
    check("R1 rt_base", rt_base, 16'h0);
    rst_n = 1'b1;

    rd("R3 locked data read", P1);
    rd("R3 locked index read", P0);
    wr("R3 locked index write", P0, 8'h07);
    wr("R3 locked data write", P1, 8'h05);
    wr("R2 unlock", P0, 8'h55);
    rd("R1 index reset", P0);
    wr("R4 set index", P0, 8'h07);
    rd("R1 select reset", P1);
    wr("R5 select write", P1, 8'h0A);
    rd("R5 select read", P1);
    wr("R4", P0, 8'h20); rd("R6 device id", P1);
    wr("R6 id write", P1, 8'h00); rd("R6 id kept", P1);
    wr("R4", P0, 8'h21); rd("R6 revision", P1);
    wr("R4", P0, 8'h60); wr("R7 hi", P1, 8'h12);
    wr("R4", P0, 8'h61); wr("R7 lo", P1, 8'h34);
    rd("R7 lo read", P1);
    rd("R9 window low edge", 16'h1234);
    rd("R9 window high edge", 16'h1333);
    rd("R9 past window", 16'h1334);
    rd("R9 below window", 16'h1233);
    wr("R4", P0, 8'h07); wr("R5", P1, 8'h03);
    wr("R4", P0, 8'h60); wr("R7 bank3 hi", P1, 8'hBE);
    rd("R7 bank3 read", P1);
    wr("R4", P0, 8'h07); wr("R5", P1, 8'h20);
    wr("R4", P0, 8'h60); wr("R7 out of range write", P1, 8'h77);
    rd("R7 out of range read", P1);
    wr("R4", P0, 8'h07); wr("R5", P1, 8'h0A);
    wr("R4", P0, 8'h60); rd("R7 bank10 kept", P1);
    wr("R4", P0, 8'h30); wr("R10 unused write", P1, 8'h5A);
    rd("R10 unused read", P1);
    wr("R4 unlock key as index", P0, 8'h55); rd("R4 index 0x55", P0);
    wr("R4", P0, 8'h07);
    op("R12 read with data write", P1, 1'b1, 1'b1, 8'h04);
    rd("R12 new value", P1);
    op("R12 read with lock key", P0, 1'b1, 1'b1, 8'hAA);
    rd("R3 locked after key", P0);
    wr("R13 foreign write", 16'h0030, 8'h55);
    rd("R13 foreign read", 16'h0030);
    wr("R2 unlock again", P0, 8'h55);
    rd("R11 index kept", P0);
    rd("R11 select kept", P1);

    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int pa, pd;
      pa = int'($urandom % 20);
      a = (pa < 9) ? P0 : (pa < 18) ? P1 : 16'($urandom);
      pd = int'($urandom % 10);
      if (a == P0)
        case (pd)
          0: d = 8'h55; 1: d = 8'hAA; 2: d = 8'h07; 3: d = 8'h20;
          4: d = 8'h21; 5, 6: d = 8'h60; 7: d = 8'h61; default: d = 8'($urandom);
        endcase
      else d = (pd < 5) ? 8'($urandom % 20) : 8'($urandom);
      if (k % 7 == 0 && m_base[10] != 16'h0) a = m_base[10] + 16'($urandom % 300);
      op("R4 random read", a, 1'($urandom), 1'($urandom), d);
    end

    @(negedge clk);
    check("R8 final rt_base", rt_base, m_base[10]);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule